// File: doc/BRIEF.md
# NAND Flash Bus Timing Controller

This block sits between a simple processor register port and a raw 8-bit NAND flash device. Software programs three strobe phase lengths and a control word. It then writes a command byte, address bytes or data to dedicated registers, and the block turns each write into correctly timed bus cycles on the flash pins. A read of the data register makes the block fetch bytes from the flash.

Every flash bus cycle has three phases: setup, active and hold. Each phase length is programmed separately, stored as the cycle count minus one. A 32-bit data access becomes four consecutive byte cycles, lowest byte first. While those cycles run, the register port is stalled, so the processor sees a single access that finishes when the last byte is done.

The block also holds the chip-enable bit (active low) and the controller enable. It shows the flash ready/busy pin in a status register after synchronising it, and it emits a one-cycle strobe that restarts an external ECC generator.

Top module: `nand_timing_ctrl`

## Requirements
- R1: After reset the timing register (offset 0x00) reads 0x00003770, meaning every phase is at its longest. The control register (offset 0x04) reads 0x2, meaning disabled with chip enable off. nandCeN is 1, nandWeN and nandReN are 1, and nandCle and nandAle are 0.
- R2: With the controller enabled, a write to offset 0x08 produces one bus cycle. nandCle is high for that whole cycle and nandAle stays low. nandWeN gives exactly one low pulse, during which nandDout equals busWdata[7:0].
- R3: With the controller enabled, a write to offset 0x0C produces one bus cycle with nandAle high in place of nandCle. It otherwise follows R2.
- R4: The timing register holds three fields: setup S in bits [13:12], active width A in bits [10:8] and hold H in bits [6:4]. In each byte cycle the envelope signal (nandCle, nandAle or nandDoe) rises S+1 cycles before nandWeN falls. The strobe then stays low for A+1 cycles, and the envelope stays high for H+1 cycles after the strobe rises.
- R5: A write to offset 0x10 with busWord=1 produces four nandWeN pulses that carry busWdata bytes 0, 1, 2 and 3 in that order. With busWord=0 it produces one pulse carrying bits [7:0].
- R6: A read of offset 0x10 with busWord=1 produces four nandReN pulses, and busRdata returns byte k of the read in bits [8k+7:8k]. With busWord=0 it produces one pulse and returns that byte in bits [7:0] with the upper bits zero. nandWeN and nandReN are never low together.
- R7: Each read byte is the nandDin value present in the last cycle nandReN is low. Any value that appears after nandReN rises is not captured.
- R8: A flash access (offset 0x08, 0x0C or 0x10) keeps busWait high from its first cycle until all its byte cycles are done. That is 1 + N·(S+A+H+3) cycles for N byte cycles. Accesses to other offsets never raise busWait, and busWait is never high without busWr or busRd.
- R9: Control bit 1 drives nandCeN directly: writing 1 deasserts chip enable and writing 0 asserts it. nandCeN changes only after a control register write.
- R10: While control bit 0 is 0, flash accesses complete with no stall. They produce no strobe, and nandWeN and nandReN stay high.
- R11: Status bit 0 at offset 0x20 reflects nandRb through a two-flop synchroniser. A change on the pin becomes visible after the second rising clock edge.
- R12: Writing the control register with bit 4 set pulses eccInit high for exactly one cycle after the write edge. Bit 4 is not stored and reads back as 0.
- R13: For write-type cycles, nandDoe is high from the start of setup through the end of hold, and it stays high across the byte cycles of a word write. nandDoe is never high while nandReN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Register offset |
| busWr | input | 1 | Write request, held until busWait is low at a clock edge |
| busRd | input | 1 | Read request, held until busWait is low at a clock edge |
| busWord | input | 1 | 1 = 32-bit data access, 0 = byte access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle busWait is low |
| busWait | output | 1 | Stall while flash bus cycles are in progress |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandCeN | output | 1 | Chip enable, active low |
| nandDout | output | 8 | Flash data bus output value |
| nandDoe | output | 1 | Flash data bus output enable |
| nandDin | input | 8 | Flash data bus input value |
| nandRb | input | 1 | Flash ready (1) / busy (0) pin |
| eccInit | output | 1 | One-cycle ECC generator restart strobe |

## Verification
The bench builds the block with its default parameters: a 2-bit setup field (1 to 4 cycles), 3-bit active and hold fields (1 to 8 cycles) and a two-stage ready synchroniser. All phase lengths are runtime register values, so the bench reaches the shortest setting (all phases one cycle), the reset-time longest setting and unequal mixes by reprogramming the timing register alone. That lets the bench measure the envelope lead, the strobe width and the hold tail at both extremes of each field without rebuilding. A wider setup field is a separate build with the setup parameter at 3.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;

  // register offsets on the processor port
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_CFG = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CTL = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_ADR = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_DAT = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STS = 6'h20;

  // field positions inside the timing and control registers
  localparam int SETUP_LSB   = 12;
  localparam int ACT_LSB     = 8;
  localparam int HOLD_LSB    = 4;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_CEN_BIT = 1;
  localparam int CTL_ECC_BIT = 4;
  localparam int STS_RDY_BIT = 0;

  // data packing
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD,
    PH_DONE
  } phase_e;

  typedef enum logic [1:0] {
    XF_CMD,
    XF_ADDR,
    XF_WDATA,
    XF_RDATA
  } xfer_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              loadWord;   // capture write word at access start
    logic              clearRd;    // clear read assembly buffer
    logic              captureRd;  // latch flash byte into current lane
    logic [LANE_W-1:0] lane;       // byte lane of the running bus cycle
  } seq_strobe_t;

endpackage

// File: rtl/nfc_ctrl.sv
`timescale 1ns/1ps
module nfc_ctrl
  import nfc_pkg::*;
#(
  parameter int SETUP_BITS = 2,
  parameter int WIDTH_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic                  busWord,
  input  logic                  ctlEn,
  input  logic [SETUP_BITS-1:0] setupFld,
  input  logic [WIDTH_BITS-1:0] actFld,
  input  logic [WIDTH_BITS-1:0] holdFld,
  output logic                  busWait,
  output logic                  nandCle,
  output logic                  nandAle,
  output logic                  nandWeN,
  output logic                  nandReN,
  output logic                  nandDoe,
  output seq_strobe_t           dpCtl
);

  localparam int CNT_W = (SETUP_BITS > WIDTH_BITS) ? SETUP_BITS : WIDTH_BITS;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

  phase_e            phase;
  xfer_e             kind;
  logic [CNT_W-1:0]  phCnt;
  logic [LANE_W-1:0] lane;
  logic [LANE_W-1:0] lastLane;

  logic hitCmd, hitAdr, hitDat;
  logic flashReq, launch, phEnd, inBurst, isRead;

  always_comb begin
    hitCmd   = (busAddr == OFF_CMD);
    hitAdr   = (busAddr == OFF_ADR);
    hitDat   = (busAddr == OFF_DAT);
    flashReq = (busWr && (hitCmd || hitAdr || hitDat)) || (busRd && hitDat);
    launch   = flashReq && ctlEn && (phase == PH_IDLE);
    phEnd    = (phCnt == '0);
  end

  // phase sequencer: setup -> active -> hold, repeated per byte lane
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      kind     <= XF_CMD;
      phCnt    <= '0;
      lane     <= '0;
      lastLane <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (launch) begin
            phase    <= PH_SETUP;
            phCnt    <= CNT_W'(setupFld);
            lane     <= '0;
            lastLane <= (hitDat && busWord) ? LAST_LANE : '0;
            if (hitCmd)      kind <= XF_CMD;
            else if (hitAdr) kind <= XF_ADDR;
            else if (busWr)  kind <= XF_WDATA;
            else             kind <= XF_RDATA;
          end
        end
        PH_SETUP: begin
          if (phEnd) begin
            phase <= PH_ACTIVE;
            phCnt <= CNT_W'(actFld);
          end else begin
            phCnt <= phCnt - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (phEnd) begin
            phase <= PH_HOLD;
            phCnt <= CNT_W'(holdFld);
          end else begin
            phCnt <= phCnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (phEnd) begin
            if (lane == lastLane) begin
              phase <= PH_DONE;
            end else begin
              phase <= PH_SETUP;
              phCnt <= CNT_W'(setupFld);
              lane  <= lane + 1'b1;
            end
          end else begin
            phCnt <= phCnt - 1'b1;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // pin and datapath strobes decoded from registered state
  always_comb begin
    inBurst = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
    isRead  = (kind == XF_RDATA);
    nandCle = inBurst && (kind == XF_CMD);
    nandAle = inBurst && (kind == XF_ADDR);
    nandDoe = inBurst && !isRead;
    nandWeN = !((phase == PH_ACTIVE) && !isRead);
    nandReN = !((phase == PH_ACTIVE) && isRead);
    busWait = flashReq && ctlEn && (phase != PH_DONE);

    dpCtl.loadWord  = launch;
    dpCtl.clearRd   = launch;
    dpCtl.captureRd = (phase == PH_ACTIVE) && phEnd && isRead;
    dpCtl.lane      = lane;
  end

endmodule

// File: rtl/nfc_datapath.sv
`timescale 1ns/1ps
module nfc_datapath
  import nfc_pkg::*;
#(
  parameter int SETUP_BITS  = 2,
  parameter int WIDTH_BITS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic [WORD_W-1:0]     busWdata,
  input  seq_strobe_t           dpCtl,
  input  logic [7:0]            nandDin,
  input  logic                  nandRb,
  output logic [SETUP_BITS-1:0] setupFld,
  output logic [WIDTH_BITS-1:0] actFld,
  output logic [WIDTH_BITS-1:0] holdFld,
  output logic                  ctlEn,
  output logic                  ctlCeN,
  output logic                  eccInit,
  output logic [WORD_W-1:0]     busRdata,
  output logic [7:0]            nandDout
);

  logic              cfgWr, ctlWr;
  logic              rdySync;
  logic [WORD_W-1:0] wordBuf;
  logic [WORD_W-1:0] rdBuf;
  logic [7:0]        laneBytes [WORD_BYTES];

  assign cfgWr = busWr && (busAddr == OFF_CFG);
  assign ctlWr = busWr && (busAddr == OFF_CTL);

  // timing and control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupFld <= '1;
      actFld   <= '1;
      holdFld  <= '1;
      ctlEn    <= 1'b0;
      ctlCeN   <= 1'b1;
      eccInit  <= 1'b0;
    end else begin
      if (cfgWr) begin
        setupFld <= busWdata[SETUP_LSB +: SETUP_BITS];
        actFld   <= busWdata[ACT_LSB +: WIDTH_BITS];
        holdFld  <= busWdata[HOLD_LSB +: WIDTH_BITS];
      end
      if (ctlWr) begin
        ctlEn  <= busWdata[CTL_EN_BIT];
        ctlCeN <= busWdata[CTL_CEN_BIT];
      end
      eccInit <= ctlWr && busWdata[CTL_ECC_BIT];
    end
  end

  // write word held for the whole access, read word assembled per lane
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordBuf <= '0;
      rdBuf   <= '0;
    end else begin
      if (dpCtl.loadWord) wordBuf <= busWdata;
      if (dpCtl.clearRd) begin
        rdBuf <= '0;
      end else if (dpCtl.captureRd) begin
        for (int k = 0; k < WORD_BYTES; k++) begin
          if (dpCtl.lane == LANE_W'(k)) rdBuf[8*k +: 8] <= nandDin;
        end
      end
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign laneBytes[g] = wordBuf[8*g +: 8];
  end
  assign nandDout = laneBytes[dpCtl.lane];

  // ready pin synchroniser
  if (SYNC_STAGES > 1) begin : g_sync_multi
    logic [SYNC_STAGES-1:0] rdyShift;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdyShift <= '0;
      else       rdyShift <= {rdyShift[SYNC_STAGES-2:0], nandRb};
    end
    assign rdySync = rdyShift[SYNC_STAGES-1];
  end else begin : g_sync_single
    logic rdyQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdyQ <= 1'b0;
      else       rdyQ <= nandRb;
    end
    assign rdySync = rdyQ;
  end

  // register read view
  always_comb begin
    busRdata = '0;
    if (busAddr == OFF_CFG) begin
      busRdata[SETUP_LSB +: SETUP_BITS] = setupFld;
      busRdata[ACT_LSB +: WIDTH_BITS]   = actFld;
      busRdata[HOLD_LSB +: WIDTH_BITS]  = holdFld;
    end else if (busAddr == OFF_CTL) begin
      busRdata[CTL_EN_BIT]  = ctlEn;
      busRdata[CTL_CEN_BIT] = ctlCeN;
    end else if (busAddr == OFF_STS) begin
      busRdata[STS_RDY_BIT] = rdySync;
    end else if (busAddr == OFF_DAT) begin
      busRdata = rdBuf;
    end
  end

endmodule

// File: rtl/nand_timing_ctrl.sv
`timescale 1ns/1ps
module nand_timing_ctrl
  import nfc_pkg::*;
#(
  parameter int SETUP_BITS  = 2,
  parameter int WIDTH_BITS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic        busWord,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busWait,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic        nandCeN,
  output logic [7:0]  nandDout,
  output logic        nandDoe,
  input  logic [7:0]  nandDin,
  input  logic        nandRb,
  output logic        eccInit
);

  logic [SETUP_BITS-1:0] setupFld;
  logic [WIDTH_BITS-1:0] actFld;
  logic [WIDTH_BITS-1:0] holdFld;
  logic                  ctlEn;
  seq_strobe_t           dpCtl;

  nfc_ctrl #(
    .SETUP_BITS (SETUP_BITS),
    .WIDTH_BITS (WIDTH_BITS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWord  (busWord),
    .ctlEn    (ctlEn),
    .setupFld (setupFld),
    .actFld   (actFld),
    .holdFld  (holdFld),
    .busWait  (busWait),
    .nandCle  (nandCle),
    .nandAle  (nandAle),
    .nandWeN  (nandWeN),
    .nandReN  (nandReN),
    .nandDoe  (nandDoe),
    .dpCtl    (dpCtl)
  );

  nfc_datapath #(
    .SETUP_BITS  (SETUP_BITS),
    .WIDTH_BITS  (WIDTH_BITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .dpCtl    (dpCtl),
    .nandDin  (nandDin),
    .nandRb   (nandRb),
    .setupFld (setupFld),
    .actFld   (actFld),
    .holdFld  (holdFld),
    .ctlEn    (ctlEn),
    .ctlCeN   (nandCeN),
    .eccInit  (eccInit),
    .busRdata (busRdata),
    .nandDout (nandDout)
  );

endmodule

// File: rtl/nfc_checker.sv
`timescale 1ns/1ps
module nfc_checker
  import nfc_pkg::*;
#(
  parameter int WIDTH_BITS = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWr,
  input logic                  busRd,
  input logic                  busWait,
  input logic                  nandCle,
  input logic                  nandAle,
  input logic                  nandWeN,
  input logic                  nandReN,
  input logic                  nandDoe,
  input logic                  nandCeN,
  input logic                  eccInit,
  input logic                  ctlEn,
  input logic [WIDTH_BITS-1:0] actFld
);

  localparam int RUN_W = WIDTH_BITS + 2;

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lowRun <= '0;
    else if (!nandWeN) lowRun <= lowRun + 1'b1;
    else               lowRun <= '0;
  end

  // R2: command and address envelopes never overlap
  a_r2_cle_ale_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  // R4: every write strobe pulse lasts the programmed active width
  a_r4_we_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> (lowRun == RUN_W'(actFld) + 1'b1));

  // R6: write and read strobes are never low together
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R8: a stall only ever answers a pending request
  a_r8_wait_has_request: assert property (@(posedge clk) disable iff (!rstN)
    busWait |-> (busWr || busRd));

  // R9: chip enable moves only after a control register write
  a_r9_ce_only_by_ctl: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == OFF_CTL) |=> $stable(nandCeN));

  // R10: no strobe while the controller is disabled
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEn |-> (nandWeN && nandReN));

  // R12: the ECC restart strobe is a single cycle
  a_r12_ecc_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    eccInit |=> !eccInit);

  // R13: the block never drives the bus while the flash does
  a_r13_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDoe);

endmodule

bind nand_timing_ctrl nfc_checker #(.WIDTH_BITS(WIDTH_BITS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busRd   (busRd),
  .busWait (busWait),
  .nandCle (nandCle),
  .nandAle (nandAle),
  .nandWeN (nandWeN),
  .nandReN (nandReN),
  .nandDoe (nandDoe),
  .nandCeN (nandCeN),
  .eccInit (eccInit),
  .ctlEn   (ctlEn),
  .actFld  (actFld)
);

// File: tb/nand_timing_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_timing_ctrl_tb_top;
  import nfc_pkg::*;

  localparam int TR_MAX = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic        busWord = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busWait;
  logic        nandCle, nandAle, nandWeN, nandReN, nandCeN, nandDoe, eccInit;
  logic [7:0]  nandDout;
  logic [7:0]  nandDin = 8'h00;
  logic        nandRb = 1'b1;

  always #2.5 clk = ~clk;

  nand_timing_ctrl dut_i (
    .clk (clk), .rstN (rstN), .busAddr (busAddr), .busWr (busWr), .busRd (busRd),
    .busWord (busWord), .busWdata (busWdata), .busRdata (busRdata), .busWait (busWait),
    .nandCle (nandCle), .nandAle (nandAle), .nandWeN (nandWeN), .nandReN (nandReN),
    .nandCeN (nandCeN), .nandDout (nandDout), .nandDoe (nandDoe), .nandDin (nandDin),
    .nandRb (nandRb), .eccInit (eccInit)
  );

  // flash model: new byte while the read strobe is low, junk after it rises
  int rdIdx = 0;
  function automatic logic [7:0] pat(input int i);
    return 8'(60 + 37 * i);
  endfunction
  always @(nandReN) begin
    if (nandReN === 1'b0) begin
      nandDin = pat(rdIdx);
      rdIdx   = rdIdx + 1;
    end else begin
      nandDin = 8'hEE;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // trace captured during a flash access, one entry per cycle
  logic       trCle [TR_MAX];
  logic       trAle [TR_MAX];
  logic       trWe  [TR_MAX];
  logic       trRe  [TR_MAX];
  logic       trDoe [TR_MAX];
  logic [7:0] trDout[TR_MAX];
  int trLen, waitCycles;
  int envCnt, lowCnt, pulses, lead, tail, firstLow;

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b1; busWdata = d;
    #1;
    check(busWait == 1'b0, "R8", "register write stalled", 32'(busWait), 0);
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    d = busRdata;
    check(busWait == 1'b0, "R8", "register read stalled", 32'(busWait), 0);
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic setCfg(input int s, input int a, input int h);
    regWrite(OFF_CFG, 32'((s << 12) | (a << 8) | (h << 4)));
  endtask

  task automatic flashXfer(input logic [5:0] a, input bit wr, input bit word,
                           input logic [31:0] wd, output logic [31:0] rd);
    bit fin;
    @(negedge clk);
    busAddr = a; busWr = wr; busRd = !wr; busWord = word; busWdata = wd;
    trLen = 0; fin = 1'b0; rd = '0;
    while (!fin) begin
      #1;
      trCle[trLen] = nandCle; trAle[trLen] = nandAle; trWe[trLen] = nandWeN;
      trRe[trLen] = nandReN; trDoe[trLen] = nandDoe; trDout[trLen] = nandDout;
      trLen++;
      if (!busWait || trLen >= TR_MAX) begin
        fin = 1'b1;
        rd  = busRdata;
      end else begin
        @(negedge clk);
      end
    end
    waitCycles = trLen - 1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; busWord = 1'b0;
  endtask

  // strobeSel: 0 write strobe, 1 read strobe; envSel: 0 cle, 1 ale, 2 doe
  task automatic analyze(input int strobeSel, input int envSel);
    int firstEnv = -1;
    int lastEnv = -1;
    int lastLow = -1;
    firstLow = -1; envCnt = 0; lowCnt = 0; pulses = 0;
    for (int i = 0; i < trLen; i++) begin
      bit e;
      bit l;
      bit pl;
      e  = (envSel == 0) ? trCle[i] : (envSel == 1) ? trAle[i] : trDoe[i];
      l  = (strobeSel == 0) ? !trWe[i] : !trRe[i];
      pl = (i == 0) ? 1'b0 : ((strobeSel == 0) ? !trWe[i-1] : !trRe[i-1]);
      if (e) begin
        envCnt++;
        if (firstEnv < 0) firstEnv = i;
        lastEnv = i;
      end
      if (l) begin
        lowCnt++;
        if (firstLow < 0) firstLow = i;
        lastLow = i;
        if (!pl) pulses++;
      end
    end
    lead = firstLow - firstEnv;
    tail = lastEnv - lastLow;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check(nandCeN == 1'b1, "R1", "nandCeN after reset", 32'(nandCeN), 1);
    check(nandWeN && nandReN, "R1", "strobes after reset", {nandWeN, nandReN}, 2'b11);
    check(!nandCle && !nandAle, "R1", "latch enables after reset", {nandCle, nandAle}, 0);
    regRead(OFF_CFG, v);
    check(v == 32'h3770, "R1", "timing register reset value", v, 32'h3770);
    regRead(OFF_CTL, v);
    check(v == 32'h2, "R1", "control register reset value", v, 32'h2);
    regRead(OFF_STS, v);
    check(v == 32'h1, "R11", "status shows ready", v, 32'h1);
  endtask

  task automatic testDisabled();
    logic [31:0] rd;
    flashXfer(OFF_CMD, 1'b1, 1'b0, 32'h70, rd);
    analyze(0, 0);
    check(waitCycles == 0, "R10", "stall while disabled", waitCycles, 0);
    check(lowCnt == 0 && envCnt == 0, "R10", "strobe activity while disabled", lowCnt + envCnt, 0);
  endtask

  task automatic testChipEnable();
    logic [31:0] v;
    regWrite(OFF_CTL, 32'h3);
    check(nandCeN == 1'b1, "R9", "nandCeN with bit1=1", 32'(nandCeN), 1);
    regRead(OFF_CTL, v);
    check(v == 32'h3, "R9", "control readback", v, 32'h3);
    regWrite(OFF_CTL, 32'h1);
    check(nandCeN == 1'b0, "R9", "nandCeN with bit1=0", 32'(nandCeN), 0);
  endtask

  task automatic testLatchCycle(input bit isAddr, input int s, input int a, input int h,
                                input logic [7:0] b);
    logic [31:0] rd;
    string rq;
    int cyc;
    rq  = isAddr ? "R3" : "R2";
    cyc = s + a + h + 3;
    setCfg(s, a, h);
    flashXfer(isAddr ? OFF_ADR : OFF_CMD, 1'b1, 1'b0, {24'hABCDEF, b}, rd);
    analyze(0, isAddr ? 1 : 0);
    check(envCnt == cyc, rq, "envelope length", envCnt, cyc);
    check(pulses == 1, rq, "write strobe pulses", pulses, 1);
    check(trDout[firstLow] == b, rq, "byte on bus", trDout[firstLow], b);
    check(lead == s + 1, "R4", "setup lead", lead, s + 1);
    check(lowCnt == a + 1, "R4", "active width", lowCnt, a + 1);
    check(tail == h + 1, "R4", "hold tail", tail, h + 1);
    check(waitCycles == 1 + cyc, "R8", "stall length single byte", waitCycles, 1 + cyc);
    analyze(0, isAddr ? 0 : 1);
    check(envCnt == 0, rq, "other latch enable stays low", envCnt, 0);
  endtask

  task automatic testWordWrite(input int s, input int a, input int h, input logic [31:0] w);
    logic [31:0] rd;
    int k;
    int cyc;
    cyc = s + a + h + 3;
    setCfg(s, a, h);
    flashXfer(OFF_DAT, 1'b1, 1'b1, w, rd);
    analyze(0, 2);
    check(pulses == 4, "R5", "word write pulses", pulses, 4);
    check(envCnt == 4 * cyc, "R13", "output enable span", envCnt, 4 * cyc);
    check(lead == s + 1, "R13", "output enable before first strobe", lead, s + 1);
    check(waitCycles == 1 + 4 * cyc, "R8", "stall length word", waitCycles, 1 + 4 * cyc);
    k = 0;
    for (int i = 0; i < trLen; i++) begin
      if (!trWe[i] && (i == 0 || trWe[i-1])) begin
        check(trDout[i] == w[8*k +: 8], "R5", "byte order", trDout[i], w[8*k +: 8]);
        k++;
      end
    end
  endtask

  task automatic testByteWrite();
    logic [31:0] rd;
    setCfg(0, 1, 0);
    flashXfer(OFF_DAT, 1'b1, 1'b0, 32'h1122335A, rd);
    analyze(0, 2);
    check(pulses == 1, "R5", "byte write pulses", pulses, 1);
    check(trDout[firstLow] == 8'h5A, "R5", "byte write value", trDout[firstLow], 8'h5A);
  endtask

  task automatic testReads();
    logic [31:0] rd;
    logic [31:0] exp;
    int base;
    setCfg(1, 2, 1);
    base = rdIdx;
    flashXfer(OFF_DAT, 1'b0, 1'b1, 32'h0, rd);
    exp = {pat(base + 3), pat(base + 2), pat(base + 1), pat(base)};
    analyze(1, 2);
    check(pulses == 4, "R6", "word read pulses", pulses, 4);
    check(lowCnt == 12, "R6", "read strobe low cycles", lowCnt, 12);
    check(envCnt == 0, "R13", "output enable during read", envCnt, 0);
    check(rd == exp, "R7", "word read assembly and capture point", rd, exp);
    check(waitCycles == 1 + 4 * 7, "R8", "stall length word read", waitCycles, 29);
    base = rdIdx;
    flashXfer(OFF_DAT, 1'b0, 1'b0, 32'h0, rd);
    exp = {24'h0, pat(base)};
    check(rd == exp, "R6", "byte read value", rd, exp);
  endtask

  task automatic testReadySync();
    @(negedge clk);
    busAddr = OFF_STS; busRd = 1'b1; nandRb = 1'b0;
    #1;
    check(busRdata[0] == 1'b1, "R11", "status before any edge", 32'(busRdata[0]), 1);
    @(posedge clk); @(negedge clk); #1;
    check(busRdata[0] == 1'b1, "R11", "status after one edge", 32'(busRdata[0]), 1);
    @(posedge clk); @(negedge clk); #1;
    check(busRdata[0] == 1'b0, "R11", "status after two edges", 32'(busRdata[0]), 0);
    nandRb = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk); #1;
    check(busRdata[0] == 1'b1, "R11", "status back to ready", 32'(busRdata[0]), 1);
    busRd = 1'b0;
  endtask

  task automatic testEccStrobe();
    logic [31:0] v;
    @(negedge clk);
    busAddr = OFF_CTL; busWr = 1'b1; busWdata = 32'h11;
    #1;
    check(eccInit == 1'b0, "R12", "strobe before write edge", 32'(eccInit), 0);
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
    #1;
    check(eccInit == 1'b1, "R12", "strobe after write edge", 32'(eccInit), 1);
    @(negedge clk); #1;
    check(eccInit == 1'b0, "R12", "strobe one cycle only", 32'(eccInit), 0);
    regRead(OFF_CTL, v);
    check(v == 32'h1, "R12", "bit4 not stored", v, 32'h1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    testReset();
    testDisabled();
    testChipEnable();
    testLatchCycle(1'b0, 3, 7, 7, 8'h70);
    testLatchCycle(1'b0, 0, 0, 0, 8'h90);
    testLatchCycle(1'b1, 1, 2, 3, 8'h5C);
    testLatchCycle(1'b1, 2, 0, 5, 8'h03);
    testWordWrite(0, 0, 0, 32'hA1B2C3D4);
    testWordWrite(2, 1, 3, 32'h0F1E2D3C);
    testByteWrite();
    testReads();
    testReadySync();
    testEccStrobe();
    finishRun();
  end

endmodule